// File: doc/BRIEF.md
# Vector Mask Conditional Execution Unit

This unit lets a vector pipeline run an if-then-else loop body without branches. It keeps two one-bit-per-element mask registers. A compare command fills a mask from a signed greater-than-zero test on every element of a vector register. An invert command writes the complement of one mask into the other. A merge command copies a source vector register into a destination register, but only at the elements whose chosen mask bit is 1. A copy command ignores the masks and writes every active element. With these commands, a compare, a merge under the first mask, an invert and a second merge under the second mask select, per element, between two data sources.

The unit works on one element per cycle. It reaches an external vector register file through a combinational read port and a write port. Each command carries its own vector length. A command is taken only while the unit is idle. A sequencer with three states drives each command:
- `ST_IDLE`: waits for a command. It goes to `ST_RUN` (the *start* transition) when the command's vector length is non-zero, or straight to `ST_DONE` (the *empty* transition) when it is zero.
- `ST_RUN`: steps the element index up from 0. It goes to `ST_DONE` (the *last* transition) after the final active element.
- `ST_DONE`: raises `done` for one cycle, then returns to `ST_IDLE` (the *retire* transition).

Top module: `vec_mask_unit`

## Requirements
- R1: A compare command (`cmd_op` = 0) sets mask bit i to 1 when element i of the source register, read as a signed value, is greater than zero. It sets the bit to 0 otherwise, which covers zero and the most negative value.
- R2: An invert command (`cmd_op` = 1) writes the complement of mask bit i of mask `cmd_msk_src` into bit i of mask `cmd_msk_dst`, for every active element.
- R3: A merge command (`cmd_op` = 2) writes source element i into the destination register only where bit i of mask `cmd_msk_src` is 1. All other destination elements keep their values.
- R4: A copy command (`cmd_op` = 3) writes every active element of the source register into the destination register, whatever the masks hold.
- R5: Elements at index `cmd_vl` or higher are never written. A `cmd_vl` above MAX_VL (8) is treated as MAX_VL.
- R6: Compare and invert commands clear every bit of the destination mask at index `cmd_vl` or higher.
- R7: Once a command is taken, elements are handled one per cycle in ascending index order. `busy` stays high for vl+1 cycles, and `done` is high only in the last of them. A vector length of 0 gives one busy cycle with `done` and no writes.
- R8: While `busy` is high, `cmd_valid` has no effect, and no second operation starts.
- R9: After reset the unit is idle with `busy` and `done` low, and both masks are all zero.
- R10: The sequence compare into mask 0, merge B under mask 0, invert mask 0 into mask 1, then merge C under mask 1 leaves each element equal to B where the original value was positive, and equal to C elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; taken when `busy` is low |
| cmd_op | input | 2 | 0 compare, 1 invert, 2 merge, 3 copy |
| cmd_src_vr | input | VR_W (2) | Source vector register |
| cmd_dst_vr | input | VR_W (2) | Destination vector register |
| cmd_msk_src | input | 1 | Mask read by invert and merge |
| cmd_msk_dst | input | 1 | Mask written by compare and invert |
| cmd_vl | input | VL_W (4) | Vector length of the command |
| busy | output | 1 | High from the cycle after acceptance until the done cycle |
| done | output | 1 | One-cycle pulse after the last active element |
| vrf_rd_reg | output | VR_W (2) | Register read by the unit |
| vrf_rd_idx | output | IDX_W (3) | Element index read |
| vrf_rd_data | input | ELEM_W (16) | Element value returned in the same cycle |
| vrf_we | output | 1 | Element write enable |
| vrf_wr_reg | output | VR_W (2) | Register written |
| vrf_wr_idx | output | IDX_W (3) | Element index written |
| vrf_wr_data | output | ELEM_W (16) | Element value written |

## Verification
The hardest case to reach from the ports is a mask bit lying above the current vector length. It has to be set by an earlier, longer command and must then be seen to be cleared, even though no port shows the masks. The stimulus first sets every bit with a full-length compare, then repeats the compare with a shorter length, then runs a full-length merge into a register filled with a sentinel. Any stale high bit would then overwrite a sentinel element. A command presented while the unit is busy is checked the same way: it is a copy that would overwrite visible data, and it is held for the whole run.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

    typedef enum logic [1:0] {
        OP_SETGT  = 2'd0,
        OP_INVERT = 2'd1,
        OP_MERGE  = 2'd2,
        OP_COPY   = 2'd3
    } vmu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vmu_state_e;

endpackage

// File: rtl/vmu_seq.sv
module vmu_seq
    import vmu_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    output logic [VL_W-1:0]  vl_eff,
    output logic [IDX_W-1:0] idx,
    output logic             run,
    output logic             busy,
    output logic             done
);

    vmu_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [VL_W-1:0]  vl_q;
    logic             last;

    // Lengths above the register depth are clamped
    always_comb vl_eff = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;

    assign last = (VL_W'(idx_q) == (vl_q - VL_W'(1)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (vl_eff == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            vl_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                idx_q <= '0;
                if (start) vl_q <= vl_eff;
            end else if (state_q == ST_RUN && !last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        run  = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  begin run = 1'b1; busy = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    assign idx = idx_q;

endmodule

// File: rtl/vmu_mask_bank.sv
module vmu_mask_bank #(
    parameter int MAX_VL   = 8,
    parameter int VL_W     = 4,
    parameter int IDX_W    = 3,
    parameter int NUM_MASK = 2,
    parameter int MSEL_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [MSEL_W-1:0] clr_sel,
    input  logic [VL_W-1:0]   clr_vl,
    input  logic              set_en,
    input  logic [MSEL_W-1:0] set_sel,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_val,
    input  logic [MSEL_W-1:0] rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);

    logic [MAX_VL-1:0] keep;
    logic [MAX_VL-1:0] mreg [NUM_MASK];

    // Bits below the command length survive the clear
    for (genvar b = 0; b < MAX_VL; b++) begin : g_keep
        assign keep[b] = (VL_W'(b) < clr_vl);
    end

    for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mreg[m] <= '0;
            end else if (clr_en && clr_sel == MSEL_W'(m)) begin
                mreg[m] <= mreg[m] & keep;
            end else if (set_en && set_sel == MSEL_W'(m)) begin
                mreg[m][set_idx] <= set_val;
            end
        end
    end

    assign rd_bit = mreg[rd_sel][rd_idx];

endmodule

// File: rtl/vmu_elem_path.sv
module vmu_elem_path
    import vmu_pkg::*;
#(
    parameter int ELEM_W = 16
) (
    input  vmu_op_e           op,
    input  logic              run,
    input  logic [ELEM_W-1:0] elem,
    input  logic              mbit,
    output logic              mask_we,
    output logic              mask_val,
    output logic              vrf_we
);

    logic gtz;

    // Positive means sign clear and not all zero
    assign gtz = ~elem[ELEM_W-1] & (|elem);

    always_comb begin
        mask_we  = 1'b0;
        mask_val = 1'b0;
        vrf_we   = 1'b0;
        unique case (op)
            OP_SETGT:  begin mask_we = run; mask_val = gtz;   end
            OP_INVERT: begin mask_we = run; mask_val = ~mbit; end
            OP_MERGE:  vrf_we = run & mbit;
            OP_COPY:   vrf_we = run;
            default: ;
        endcase
    end

endmodule

// File: rtl/vec_mask_unit.sv
module vec_mask_unit
    import vmu_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int MAX_VL = 8,
    parameter int NUM_VR = 4,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int VR_W  = $clog2(NUM_VR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [VR_W-1:0]   cmd_src_vr,
    input  logic [VR_W-1:0]   cmd_dst_vr,
    input  logic              cmd_msk_src,
    input  logic              cmd_msk_dst,
    input  logic [VL_W-1:0]   cmd_vl,
    output logic              busy,
    output logic              done,
    output logic [VR_W-1:0]   vrf_rd_reg,
    output logic [IDX_W-1:0]  vrf_rd_idx,
    input  logic [ELEM_W-1:0] vrf_rd_data,
    output logic              vrf_we,
    output logic [VR_W-1:0]   vrf_wr_reg,
    output logic [IDX_W-1:0]  vrf_wr_idx,
    output logic [ELEM_W-1:0] vrf_wr_data
);

    vmu_op_e          op_in, op_q;
    logic [VR_W-1:0]  src_q, dst_q;
    logic             msrc_q, mdst_q;
    logic             accept, clr_en, run;
    logic [VL_W-1:0]  vl_eff;
    logic [IDX_W-1:0] idx;
    logic             mbit, mask_we, mask_val;

    assign op_in  = vmu_op_e'(cmd_op);
    assign accept = cmd_valid & ~busy;
    assign clr_en = accept & (op_in == OP_SETGT || op_in == OP_INVERT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_SETGT;
            src_q  <= '0;
            dst_q  <= '0;
            msrc_q <= 1'b0;
            mdst_q <= 1'b0;
        end else if (accept) begin
            op_q   <= op_in;
            src_q  <= cmd_src_vr;
            dst_q  <= cmd_dst_vr;
            msrc_q <= cmd_msk_src;
            mdst_q <= cmd_msk_dst;
        end
    end

    vmu_seq #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .vl_in(cmd_vl),
        .vl_eff(vl_eff), .idx(idx), .run(run), .busy(busy), .done(done)
    );

    vmu_mask_bank #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_masks (
        .clk(clk), .rst_n(rst_n),
        .clr_en(clr_en), .clr_sel(cmd_msk_dst), .clr_vl(vl_eff),
        .set_en(mask_we), .set_sel(mdst_q), .set_idx(idx), .set_val(mask_val),
        .rd_sel(msrc_q), .rd_idx(idx), .rd_bit(mbit)
    );

    vmu_elem_path #(.ELEM_W(ELEM_W)) u_path (
        .op(op_q), .run(run), .elem(vrf_rd_data), .mbit(mbit),
        .mask_we(mask_we), .mask_val(mask_val), .vrf_we(vrf_we)
    );

    assign vrf_rd_reg  = src_q;
    assign vrf_rd_idx  = idx;
    assign vrf_wr_reg  = dst_q;
    assign vrf_wr_idx  = idx;
    assign vrf_wr_data = vrf_rd_data;

endmodule

// File: rtl/vec_mask_unit_chk.sv
module vec_mask_unit_chk #(
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [VL_W-1:0]  cmd_vl,
    input logic             busy,
    input logic             done,
    input logic             vrf_we,
    input logic [IDX_W-1:0] vrf_rd_idx,
    input logic [IDX_W-1:0] vrf_wr_idx
);

    logic [VL_W-1:0] act_vl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_vl <= '0;
        else if (cmd_valid && !busy)
            act_vl <= (cmd_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_vl;
    end

    a_r5_write_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_we |-> (VL_W'(vrf_wr_idx) < act_vl));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && $past(busy && !done)) |->
            (vrf_rd_idx == IDX_W'($past(vrf_rd_idx) + 1'b1)));

    a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r4_write_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_we |-> (busy && !done));

    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

endmodule

bind vec_mask_unit vec_mask_unit_chk #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_vl(cmd_vl),
    .busy(busy), .done(done), .vrf_we(vrf_we),
    .vrf_rd_idx(vrf_rd_idx), .vrf_wr_idx(vrf_wr_idx)
);

// File: tb/tb_vec_mask_unit.sv
module tb_vec_mask_unit;

    localparam int CLK_PERIOD = 10;
    localparam int ELEM_W = 16;
    localparam int MAX_VL = 8;
    localparam int NUM_VR = 4;
    localparam int VL_W   = 4;
    localparam int IDX_W  = 3;
    localparam int VR_W   = 2;
    localparam logic [ELEM_W-1:0] SENT = 16'hDEAD;
    localparam int NTV = 5;

    // Table: source elements {e7..e0}, vector length, expected mask
    localparam logic [8*ELEM_W-1:0] TV_A [NTV] = '{
        {16'h0002,16'hFFFB,16'h0005,16'h8000,16'h7FFF,16'hFFFF,16'h0000,16'h0001},
        {8{16'h0000}},
        {8{16'h0007}},
        {8{16'hFFFF}},
        {16'h0009,16'h0009,16'h0009,16'h0009,16'h0000,16'h0004,16'hFFFE,16'h0003}
    };
    localparam logic [3:0] TV_VL [NTV] = '{4'd8, 4'd8, 4'd5, 4'd8, 4'd3};
    localparam logic [7:0] TV_M  [NTV] = '{8'hA9, 8'h00, 8'h1F, 8'h00, 8'h05};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [VR_W-1:0] cmd_src_vr = '0, cmd_dst_vr = '0;
    logic cmd_msk_src = 1'b0, cmd_msk_dst = 1'b0;
    logic [VL_W-1:0] cmd_vl = '0;
    logic busy, done, vrf_we;
    logic [VR_W-1:0] vrf_rd_reg, vrf_wr_reg;
    logic [IDX_W-1:0] vrf_rd_idx, vrf_wr_idx;
    logic [ELEM_W-1:0] vrf_rd_data, vrf_wr_data;

    logic [ELEM_W-1:0] vrf [NUM_VR][MAX_VL];
    logic [ELEM_W-1:0] exp_v [MAX_VL];
    int tests = 0, fails = 0;
    int bc, dc, wn;
    int wlog [16];
    bit idle_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign vrf_rd_data = vrf[vrf_rd_reg][vrf_rd_idx];

    vec_mask_unit #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .NUM_VR(NUM_VR)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_vr(cmd_src_vr), .cmd_dst_vr(cmd_dst_vr),
        .cmd_msk_src(cmd_msk_src), .cmd_msk_dst(cmd_msk_dst), .cmd_vl(cmd_vl),
        .busy(busy), .done(done),
        .vrf_rd_reg(vrf_rd_reg), .vrf_rd_idx(vrf_rd_idx), .vrf_rd_data(vrf_rd_data),
        .vrf_we(vrf_we), .vrf_wr_reg(vrf_wr_reg), .vrf_wr_idx(vrf_wr_idx),
        .vrf_wr_data(vrf_wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_vec(input int r, input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < MAX_VL; i++)
            if (vrf[r][i] !== exp_v[i] && ok) begin ok = 1'b0; bad = i; end
        check(ok, req, int'(vrf[r][bad]), int'(exp_v[bad]));
    endtask

    task automatic fill(input int r, input logic [ELEM_W-1:0] base, input bit ramp);
        for (int i = 0; i < MAX_VL; i++) vrf[r][i] = ramp ? base + ELEM_W'(i) : base;
    endtask

    task automatic load_tv(input int r, input int k);
        for (int i = 0; i < MAX_VL; i++) vrf[r][i] = TV_A[k][i*ELEM_W +: ELEM_W];
    endtask

    // Issue one command and follow it to completion; junk holds a
    // conflicting copy request for the whole run
    task automatic run_op(input logic [1:0] op, input logic [1:0] s, input logic [1:0] d,
                          input bit ms, input bit md, input logic [3:0] vl, input bit junk);
        int guard = 0;
        @(negedge clk);
        cmd_op = op; cmd_src_vr = s; cmd_dst_vr = d;
        cmd_msk_src = ms; cmd_msk_dst = md; cmd_vl = vl; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bc = 0; dc = 0; wn = 0;
        if (junk) begin
            cmd_op = 2'd3; cmd_src_vr = 2'd1; cmd_dst_vr = 2'd3; cmd_vl = 4'd8;
            cmd_valid = 1'b1;
        end
        while (1) begin
            if (busy) bc++;
            if (vrf_we) begin
                vrf[vrf_wr_reg][vrf_wr_idx] = vrf_wr_data;
                if (wn < 16) wlog[wn] = int'(vrf_wr_idx);
                wn++;
            end
            if (done) begin dc++; break; end
            guard++;
            if (guard > 100) begin check(1'b0, "R7 command never finished", guard, 0); break; end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        idle_after = !busy && !done;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NUM_VR; r++) fill(r, '0, 1'b0);
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy && !done, "R9 busy/done low after reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R9 idle after reset release", {busy, done}, 0);
        fill(1, 16'h1000, 1'b1); fill(3, SENT, 1'b0);
        run_op(2'd2, 2'd1, 2'd3, 1'b1, 1'b0, 4'd8, 1'b0);
        check(wn == 0, "R9 mask 1 clear after reset", wn, 0);
        run_op(2'd2, 2'd1, 2'd3, 1'b0, 1'b0, 4'd8, 1'b0);
        check(wn == 0, "R9 mask 0 clear after reset", wn, 0);

        // R1/R3: compare patterns, observed by a merge into a sentinel register
        for (int k = 0; k < NTV; k++) begin
            load_tv(0, k); fill(1, 16'h1000, 1'b1); fill(3, SENT, 1'b0);
            run_op(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, TV_VL[k], 1'b0);
            run_op(2'd2, 2'd1, 2'd3, 1'b0, 1'b0, 4'd8, 1'b0);
            for (int i = 0; i < MAX_VL; i++)
                exp_v[i] = TV_M[k][i] ? 16'h1000 + ELEM_W'(i) : SENT;
            check_vec(3, $sformatf("R1 R3 compare/merge vector %0d", k));
        end

        // R7/R4/R5: copy of length 4
        fill(1, 16'h1000, 1'b1); fill(2, 16'h5555, 1'b0);
        run_op(2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 4'd4, 1'b0);
        check(bc == 5 && dc == 1, "R7 busy cycles for vl=4", bc*16 + dc, 5*16 + 1);
        check(wn == 4 && wlog[0] == 0 && wlog[1] == 1 && wlog[2] == 2 && wlog[3] == 3,
              "R7 ascending element order", wlog[0]*4096 + wlog[1]*256 + wlog[2]*16 + wlog[3], 16'h0123);
        check(idle_after, "R7 idle after done", int'(idle_after), 1);
        for (int i = 0; i < MAX_VL; i++) exp_v[i] = (i < 4) ? 16'h1000 + ELEM_W'(i) : 16'h5555;
        check_vec(2, "R4 R5 copy writes active elements only");

        // R5: length clamp
        fill(2, 16'h5555, 1'b0);
        run_op(2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 4'd15, 1'b0);
        check(wn == 8 && bc == 9, "R5 length above depth clamped", wn*16 + bc, 8*16 + 9);

        // R7/R5: zero length
        run_op(2'd3, 2'd1, 2'd2, 1'b0, 1'b0, 4'd0, 1'b0);
        check(wn == 0 && bc == 1 && dc == 1, "R7 zero length", wn*256 + bc*16 + dc, 16'h011);

        // R6: stale high mask bits cleared by a shorter compare
        fill(0, 16'h0007, 1'b0);
        run_op(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0);
        run_op(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3, 1'b0);
        fill(3, SENT, 1'b0);
        run_op(2'd2, 2'd1, 2'd3, 1'b0, 1'b0, 4'd8, 1'b0);
        for (int i = 0; i < MAX_VL; i++) exp_v[i] = (i < 3) ? 16'h1000 + ELEM_W'(i) : SENT;
        check_vec(3, "R6 mask bits above vl cleared");

        // R2: invert of 0xA9 at vl=4 gives bits 1,2 only
        load_tv(0, 0);
        run_op(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0);
        run_op(2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 4'd4, 1'b0);
        fill(3, SENT, 1'b0);
        run_op(2'd2, 2'd1, 2'd3, 1'b1, 1'b0, 4'd8, 1'b0);
        for (int i = 0; i < MAX_VL; i++) exp_v[i] = (i == 1 || i == 2) ? 16'h1000 + ELEM_W'(i) : SENT;
        check_vec(3, "R2 R6 inverted mask");

        // R8: conflicting copy held during a merge is ignored
        fill(2, 16'h2000, 1'b1); fill(3, SENT, 1'b0);
        run_op(2'd2, 2'd2, 2'd3, 1'b1, 1'b0, 4'd8, 1'b1);
        for (int i = 0; i < MAX_VL; i++) exp_v[i] = (i == 1 || i == 2) ? 16'h2000 + ELEM_W'(i) : SENT;
        check_vec(3, "R8 command while busy ignored");
        check(idle_after, "R8 no second operation started", int'(idle_after), 1);

        // R10: two-pass select between B (vr1) and C (vr2)
        load_tv(0, 0); fill(1, 16'h1000, 1'b1); fill(2, 16'h2000, 1'b1);
        run_op(2'd3, 2'd0, 2'd3, 1'b0, 1'b0, 4'd8, 1'b0);
        run_op(2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0);
        run_op(2'd2, 2'd1, 2'd3, 1'b0, 1'b0, 4'd8, 1'b0);
        run_op(2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 4'd8, 1'b0);
        run_op(2'd2, 2'd2, 2'd3, 1'b1, 1'b0, 4'd8, 1'b0);
        for (int i = 0; i < MAX_VL; i++)
            exp_v[i] = TV_M[0][i] ? 16'h1000 + ELEM_W'(i) : 16'h2000 + ELEM_W'(i);
        check_vec(3, "R10 two-pass select");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule